// File: doc/BRIEF.md
# Execute Stage Operand Forwarding Unit

This block picks the two ALU operands for the execute stage of a five-stage in-order pipeline. Each operand has three possible sources. The first is the value read from the register file during decode and carried in the decode/execute register. The second is the ALU result of the instruction one stage ahead, held in the execute/memory register. The third is the final value that the memory/writeback register is about to commit.

The unit compares each execute-stage source register number with the destination numbers of the two older instructions. A destination counts as a producer only when its write enable is set and its number is nonzero. When both older instructions write the source, the younger one (execute/memory) wins, because it holds the newer value. The block is purely combinational. It drives the selected operand values and a 2-bit select code per operand, which the pipeline can use for debug or for steering the ALU input muxes.

Top module: `exec_fwd_unit`

## Requirements
- R1: When the execute/memory write enable is 1, its destination is nonzero and equals an operand's source number, that operand's select is 2'b10 and its value is the execute/memory data.
- R2: When R1 does not apply to an operand, and the memory/writeback write enable is 1 with a nonzero destination equal to the source, the select is 2'b01 and the value is the memory/writeback data.
- R3: When both older stages write the same nonzero source register, the execute/memory stage takes priority (select 2'b10).
- R4: When no enabled producer matches, or the matching stages have their write enable at 0, the select is 2'b00 and the value is the register-file value passed in.
- R5: Source register 0 is never forwarded. It takes select 2'b00 even when an enabled stage names destination 0 with other data.
- R6: Operands A and B are decided independently. They may use different paths in the same cycle.
- R7: Outputs follow the inputs in the same cycle with no register on the path, and the select code is never 2'b11.
- R8: A back-to-back dependent chain whose register values are supplied as a real pipeline would supply them gets the architecturally correct operands on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Source register number of operand A in the execute stage |
| ex_src_b | input | 5 | Source register number of operand B in the execute stage |
| ex_rf_a | input | 32 | Register-file value of operand A from decode |
| ex_rf_b | input | 32 | Register-file value of operand B from decode |
| exm_wr_en | input | 1 | Execute/memory instruction writes a register |
| exm_dst | input | 5 | Execute/memory destination register number |
| exm_val | input | 32 | Execute/memory ALU result |
| mwb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| mwb_dst | input | 5 | Memory/writeback destination register number |
| mwb_val | input | 32 | Memory/writeback final value |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |
| pick_a | output | 2 | Select code for A: 00 register file, 10 execute/memory, 01 memory/writeback |
| pick_b | output | 2 | Select code for B, same encoding |

## Verification
Every result of this block is due in the same cycle as the stimulus that causes it, because no register lies between the inputs and the outputs. The bench changes the inputs shortly after a rising edge and samples all four outputs at the following falling edge, half a period later. By then the combinational paths have settled and the next change has not yet begun. A behavioural reference computes the expected select and value for each vector at that point. The dependent-chain test rebuilds each cycle's pipeline contents from snapshots of register state that the bench keeps itself.

// File: rtl/exec_fwd_pkg.sv
package exec_fwd_pkg;
  typedef enum logic [1:0] {
    PICK_RF  = 2'b00,
    PICK_MWB = 2'b01,
    PICK_EXM = 2'b10
  } pick_e;
endpackage

// File: rtl/fwd_hit.sv
// One producer stage versus one consumer source: a real producer match
module fwd_hit #(
  parameter int REG_AW = 5
) (
  input  logic              wr_en,
  input  logic [REG_AW-1:0] dst,
  input  logic [REG_AW-1:0] src,
  output logic              hit
);
  always_comb begin
    hit = wr_en && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/fwd_prio.sv
// Priority between the two producer stages; younger one wins
module fwd_prio
  import exec_fwd_pkg::*;
(
  input  logic  hit_exm,
  input  logic  hit_mwb,
  output pick_e pick
);
  always_comb begin
    if (hit_exm)      pick = PICK_EXM;
    else if (hit_mwb) pick = PICK_MWB;
    else              pick = PICK_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
// Operand data mux driven by the select code
module fwd_mux
  import exec_fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  pick_e             pick,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [DATA_W-1:0] q
);
  always_comb begin
    unique case (pick)
      PICK_EXM: q = exm_val;
      PICK_MWB: q = mwb_val;
      default:  q = rf_val;
    endcase
  end
endmodule

// File: rtl/exec_fwd_unit.sv
module exec_fwd_unit
  import exec_fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [DATA_W-1:0] ex_rf_a,
  input  logic [DATA_W-1:0] ex_rf_b,
  input  logic              exm_wr_en,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic [DATA_W-1:0] exm_val,
  input  logic              mwb_wr_en,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [1:0]        pick_a,
  output logic [1:0]        pick_b
);
  localparam int NUM_OPND = 2;

  logic [REG_AW-1:0] src_v  [NUM_OPND];
  logic [DATA_W-1:0] rf_v   [NUM_OPND];
  logic [DATA_W-1:0] opnd_v [NUM_OPND];
  pick_e             pick_v [NUM_OPND];

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign rf_v[0]  = ex_rf_a;
  assign rf_v[1]  = ex_rf_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic hit_exm;
    logic hit_mwb;

    fwd_hit #(.REG_AW(REG_AW)) u_hit_exm (
      .wr_en(exm_wr_en), .dst(exm_dst), .src(src_v[g]), .hit(hit_exm)
    );
    fwd_hit #(.REG_AW(REG_AW)) u_hit_mwb (
      .wr_en(mwb_wr_en), .dst(mwb_dst), .src(src_v[g]), .hit(hit_mwb)
    );
    fwd_prio u_prio (
      .hit_exm(hit_exm), .hit_mwb(hit_mwb), .pick(pick_v[g])
    );
    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .pick(pick_v[g]), .rf_val(rf_v[g]), .exm_val(exm_val),
      .mwb_val(mwb_val), .q(opnd_v[g])
    );

    always_comb begin
      AST_EXM_DATA: assert (pick_v[g] != PICK_EXM || opnd_v[g] == exm_val) else $error("exm data"); // R1
      AST_MWB_DATA: assert (pick_v[g] != PICK_MWB || opnd_v[g] == mwb_val) else $error("mwb data"); // R2
      AST_EXM_WINS: assert (!(exm_wr_en && exm_dst == src_v[g] && src_v[g] != '0) || pick_v[g] == PICK_EXM) else $error("prio"); // R3
      AST_RF_DATA:  assert (pick_v[g] != PICK_RF || opnd_v[g] == rf_v[g]) else $error("rf data"); // R4
      AST_ZERO_SRC: assert (src_v[g] != '0 || pick_v[g] == PICK_RF) else $error("r0"); // R5
      AST_LEGAL_PICK: assert (pick_v[g] != pick_e'(2'b11)) else $error("bad pick"); // R7
    end
  end

  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];
  assign pick_a = pick_v[0];
  assign pick_b = pick_v[1];
endmodule

// File: tb/exec_fwd_unit_tb.sv
module exec_fwd_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  ex_src_a, ex_src_b, exm_dst, mwb_dst;
  logic [31:0] ex_rf_a, ex_rf_b, exm_val, mwb_val, opnd_a, opnd_b;
  logic        exm_wr_en, mwb_wr_en;
  logic [1:0]  pick_a, pick_b;

  int n_chk = 0;
  int n_bad = 0;

  exec_fwd_unit dut_i (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .exm_wr_en(exm_wr_en), .exm_dst(exm_dst), .exm_val(exm_val),
    .mwb_wr_en(mwb_wr_en), .mwb_dst(mwb_dst), .mwb_val(mwb_val),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pick_a(pick_a), .pick_b(pick_b)
  );

  function automatic logic [1:0] ref_pick(input logic [4:0] s);
    if (s != 0 && exm_wr_en && exm_dst == s) return 2'b10;
    if (s != 0 && mwb_wr_en && mwb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] ref_val(input logic [1:0] p, input logic [31:0] rf);
    if (p == 2'b10) return exm_val;
    if (p == 2'b01) return mwb_val;
    return rf;
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive just after the rising edge, check at the falling edge
  task automatic apply(input string req, input logic [4:0] sa, input logic [4:0] sb,
                       input logic we1, input logic [4:0] d1, input logic we2, input logic [4:0] d2);
    @(posedge clk); #1;
    ex_src_a = sa; ex_src_b = sb;
    ex_rf_a = 32'hA000_0000 | sa; ex_rf_b = 32'hB000_0000 | sb;
    exm_wr_en = we1; exm_dst = d1; exm_val = 32'hE000_0000 | $urandom_range(0, 4095);
    mwb_wr_en = we2; mwb_dst = d2; mwb_val = 32'hD000_0000 | $urandom_range(0, 4095);
    @(negedge clk);
    begin
      logic [1:0] pa, pb;
      pa = ref_pick(sa); pb = ref_pick(sb);
      cmp({req, " pick_a"}, {30'd0, pick_a}, {30'd0, pa});
      cmp({req, " pick_b"}, {30'd0, pick_b}, {30'd0, pb});
      cmp({req, " opnd_a"}, opnd_a, ref_val(pa, ex_rf_a));
      cmp({req, " opnd_b"}, opnd_b, ref_val(pb, ex_rf_b));
    end
  endtask

  // R8: dependent chain; ops 0 add, 1 sub, 2 or, 3 and
  localparam int NI = 5;
  int          c_op [NI] = '{0, 1, 2, 0, 3};
  logic [4:0]  c_rd [NI] = '{3, 5, 6, 7, 3};
  logic [4:0]  c_ra [NI] = '{1, 3, 3, 3, 7};
  logic [4:0]  c_rb [NI] = '{2, 4, 4, 6, 3};
  logic        c_we [NI] = '{1, 1, 1, 1, 0};
  logic [31:0] snap [NI+1][8];
  logic [31:0] c_res [NI];

  task automatic run_chain();
    for (int r = 0; r < 8; r++) snap[0][r] = 32'd10 * r + 32'd7;
    snap[0][0] = 0;
    for (int i = 0; i < NI; i++) begin
      logic [31:0] x, y;
      x = snap[i][c_ra[i]]; y = snap[i][c_rb[i]];
      case (c_op[i])
        0: c_res[i] = x + y;
        1: c_res[i] = x - y;
        2: c_res[i] = x | y;
        default: c_res[i] = x & y;
      endcase
      for (int r = 0; r < 8; r++) snap[i+1][r] = snap[i][r];
      if (c_we[i] && c_rd[i] != 0) snap[i+1][c_rd[i]] = c_res[i];
    end
    for (int i = 0; i < NI; i++) begin
      int k;
      k = (i >= 2) ? i - 2 : 0;
      @(posedge clk); #1;
      ex_src_a = c_ra[i]; ex_src_b = c_rb[i];
      ex_rf_a = snap[k][c_ra[i]]; ex_rf_b = snap[k][c_rb[i]];
      exm_wr_en = (i >= 1) ? c_we[i-1] : 1'b0;
      exm_dst   = (i >= 1) ? c_rd[i-1] : 5'd0;
      exm_val   = (i >= 1) ? c_res[i-1] : 32'd0;
      mwb_wr_en = (i >= 2) ? c_we[i-2] : 1'b0;
      mwb_dst   = (i >= 2) ? c_rd[i-2] : 5'd0;
      mwb_val   = (i >= 2) ? c_res[i-2] : 32'd0;
      @(negedge clk);
      cmp("R8 chain opnd_a", opnd_a, snap[i][c_ra[i]]);
      cmp("R8 chain opnd_b", opnd_b, snap[i][c_rb[i]]);
    end
  endtask

  initial begin
    ex_src_a = 0; ex_src_b = 0; ex_rf_a = 0; ex_rf_b = 0;
    exm_wr_en = 0; exm_dst = 0; exm_val = 0;
    mwb_wr_en = 0; mwb_dst = 0; mwb_val = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    cmp("R4 idle pick_a", {30'd0, pick_a}, 32'd0);
    cmp("R4 idle opnd_b", opnd_b, 32'd0);
    apply("R1 exm", 5'd3, 5'd9, 1, 5'd3, 0, 5'd3);
    apply("R2 mwb", 5'd4, 5'd9, 1, 5'd8, 1, 5'd4);
    apply("R3 both", 5'd6, 5'd6, 1, 5'd6, 1, 5'd6);
    apply("R4 no we", 5'd7, 5'd8, 0, 5'd7, 0, 5'd8);
    apply("R4 nomatch", 5'd1, 5'd2, 1, 5'd3, 1, 5'd4);
    apply("R5 zero", 5'd0, 5'd0, 1, 5'd0, 1, 5'd0);
    apply("R6 split", 5'd11, 5'd12, 1, 5'd11, 1, 5'd12);
    apply("R6 split2", 5'd12, 5'd11, 1, 5'd11, 1, 5'd12);
    apply("R3 exm-we-low", 5'd5, 5'd5, 0, 5'd5, 1, 5'd5);
    for (int i = 0; i < 300; i++)
      apply("R7 random", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)));
    run_chain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule